// File: doc/BRIEF.md
# Relocatable Prioritized Address Region Decoder

This block takes a 16-bit bus address and reports which memory region owns it. It also reports the byte offset of the address inside that region. Five regions share the address space:

- an I/O register block
- an EEPROM window
- an NVRAM window
- an on-chip RAM window
- an external RAM window

The I/O block and the on-chip RAM window can move at run time. Their positions come from one 8-bit relocation register. The low nibble of that register gives the I/O page and the high nibble gives the on-chip RAM page. The EEPROM, NVRAM and external RAM windows sit at fixed bases, each with a fixed size, all set by parameters.

When windows overlap, a fixed priority decides which region owns the address. If no window claims the address, the block raises an unmapped flag, which the bus fabric can use to return a bus error.

The relocation register lives inside the I/O block, at a parameterised byte offset. A bus write to that offset loads it. The new placement applies from the next clock cycle. The decode for the writing cycle still uses the old placement.

The size of the I/O block depends on a CPU-variant parameter. The small variant has 64 bytes and the large variant has 1024 bytes.

Top module: `mem_region_decoder`

## Requirements
- R1: After reset the relocation value is 0x01. The on-chip RAM window therefore starts at 0x0000 and the I/O block starts at 0x1000.
- R2: The select output is one-hot with this bit assignment: bit 0 = I/O, bit 1 = EEPROM, bit 2 = NVRAM, bit 3 = on-chip RAM, bit 4 = external RAM. At most one bit is ever set.
- R3: The offset output equals the address minus the base of the selected region, modulo 2^16. It is zero when nothing is selected.
- R4: The I/O base is relocation bits [3:0] placed at address bits [15:12], with the lower address bits zero.
- R5: The on-chip RAM base is relocation bits [7:4] placed at address bits [15:12], with the lower address bits zero.
- R6: On overlap the priority is I/O > EEPROM > NVRAM > on-chip RAM > external RAM. With default parameters the windows are: EEPROM 0xB000–0xB7FF, NVRAM 0x8000–0x9FFF, on-chip RAM 256 bytes, external RAM 0x2000–0x7FFF.
- R7: The I/O block covers offsets 0x000–0x03F when the variant parameter is 0, and offsets 0x000–0x3FF when it is 1.
- R8: A cycle with the write enable high, I/O selected and offset equal to the relocation offset (default 0x03C) loads the write data into the relocation register. The decode in that cycle uses the old value. The decode from the next cycle onward uses the new value.
- R9: A write with any other offset, or a write whose address is claimed by a region other than I/O, leaves the relocation value unchanged.
- R10: The unmapped output is high exactly when no region claims the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 16 | Bus address being decoded |
| wr_en | input | 1 | Bus write strobe for the current address |
| wr_data | input | 8 | Bus write data; the relocation register takes it when addressed |
| sel | output | 5 | One-hot region select (bit order given in R2) |
| offset | output | 16 | Address minus base of the selected region |
| unmapped | output | 1 | No region claims the address |

## Verification
The bench targets the overlap cases and the window edges.

- **I/O and on-chip RAM on the same page.** A decoder with the priority inverted would hand I/O offsets to RAM.
- **I/O moved on top of the EEPROM, and on-chip RAM moved under NVRAM or over external RAM.** A wrong priority here returns the wrong one-hot bit.
- **Window ends and one-past-the-end addresses, in both I/O sizes.** An off-by-one size compare either claims an extra byte or drops the last one.
- **Relocation timing.** The bench checks the decode in the writing cycle and in the cycle after it. A design that forwards the new value early, or that loads on a near-miss write, moves a window at the wrong time.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NREG    = 5;
  localparam int RELOC_W = 8;

  typedef enum int {
    RG_IO   = 0,
    RG_EEP  = 1,
    RG_NVR  = 2,
    RG_IRAM = 3,
    RG_XRAM = 4
  } region_e;
endpackage

// File: rtl/mrd_window.sv
module mrd_window #(
  parameter int AW   = 16,
  parameter int SIZE = 64
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] offset
);
  localparam logic [AW:0] LIMIT = (AW+1)'(SIZE);

  logic [AW:0] diff;

  always_comb begin
    diff   = {1'b0, addr} - {1'b0, base};
    // A borrow out of the top bit means the address lies below the base.
    hit    = ~diff[AW] && ({1'b0, diff[AW-1:0]} < LIMIT);
    offset = diff[AW-1:0];
  end
endmodule

// File: rtl/mrd_prio_pick.sv
module mrd_prio_pick #(
  parameter int N  = 5,
  parameter int AW = 16
) (
  input  logic [N-1:0]         hit,
  input  logic [N-1:0][AW-1:0] offs,
  output logic [N-1:0]         sel,
  output logic [AW-1:0]        offset,
  output logic                 unmapped
);
  always_comb begin
    sel    = '0;
    offset = '0;
    // Walk from lowest priority to highest so that the last match wins.
    for (int i = N-1; i >= 0; i--) begin
      if (hit[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        offset = offs[i];
      end
    end
    unmapped = ~|hit;
  end
endmodule

// File: rtl/mrd_reloc_reg.sv
module mrd_reloc_reg #(
  parameter int              W   = 8,
  parameter logic [W-1:0]    RST = 8'h01
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  output logic         rst_sync_n,
  output logic [W-1:0] reloc
);
  logic         sync_q1;
  logic         sync_q2;
  logic         load_en;
  logic [W-1:0] reloc_d;
  logic [W-1:0] reloc_q;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= 1'b1;
      sync_q2 <= sync_q1;
    end
  end

  assign rst_sync_n = sync_q2;

  always_comb begin
    load_en = wr_hit;
    reloc_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      reloc_q <= RST;
    end else if (load_en) begin
      reloc_q <= reloc_d;
    end
  end

  assign reloc = reloc_q;
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CPU_VARIANT = 0,
  parameter int EEP_BASE    = 'hB000,
  parameter int EEP_SIZE    = 'h0800,
  parameter int NVR_BASE    = 'h8000,
  parameter int NVR_SIZE    = 'h2000,
  parameter int IRAM_SIZE   = 'h0100,
  parameter int XRAM_BASE   = 'h2000,
  parameter int XRAM_SIZE   = 'h6000,
  parameter int RELOC_OFS   = 'h03C,
  parameter logic [RELOC_W-1:0] RELOC_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [NREG-1:0]   sel,
  output logic [ADDR_W-1:0] offset,
  output logic              unmapped
);
  localparam int PAGE_LO = ADDR_W - 4;
  localparam int IO_SIZE = (CPU_VARIANT == 0) ? 64 : 1024;

  logic [RELOC_W-1:0]           reloc_q;
  logic                         rst_sync_n;
  logic                         wr_hit;
  logic [NREG-1:0][ADDR_W-1:0]  bases;
  logic [NREG-1:0]              hits;
  logic [NREG-1:0][ADDR_W-1:0]  offs;

  always_comb begin
    bases          = '0;
    bases[RG_IO]   = {reloc_q[3:0], {PAGE_LO{1'b0}}};
    bases[RG_EEP]  = ADDR_W'(EEP_BASE);
    bases[RG_NVR]  = ADDR_W'(NVR_BASE);
    bases[RG_IRAM] = {reloc_q[7:4], {PAGE_LO{1'b0}}};
    bases[RG_XRAM] = ADDR_W'(XRAM_BASE);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_win
    localparam int SZ = (g == RG_IO)  ? IO_SIZE  :
                        (g == RG_EEP) ? EEP_SIZE :
                        (g == RG_NVR) ? NVR_SIZE :
                        (g == RG_IRAM)? IRAM_SIZE : XRAM_SIZE;
    mrd_window #(.AW(ADDR_W), .SIZE(SZ)) win_i (
      .base   (bases[g]),
      .addr   (addr),
      .hit    (hits[g]),
      .offset (offs[g])
    );
  end

  mrd_prio_pick #(.N(NREG), .AW(ADDR_W)) pick_i (
    .hit      (hits),
    .offs     (offs),
    .sel      (sel),
    .offset   (offset),
    .unmapped (unmapped)
  );

  assign wr_hit = wr_en && sel[RG_IO] && (offset == ADDR_W'(RELOC_OFS));

  mrd_reloc_reg #(.W(RELOC_W), .RST(RELOC_RST)) reloc_i (
    .clk        (clk),
    .arst_n     (rst_n),
    .wr_hit     (wr_hit),
    .wr_data    (wr_data),
    .rst_sync_n (rst_sync_n),
    .reloc      (reloc_q)
  );
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int AW        = 16,
  parameter int IO_SIZE   = 64,
  parameter int RELOC_OFS = 'h03C
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic [4:0]    sel,
  input logic [AW-1:0] offset,
  input logic          unmapped,
  input logic [7:0]    reloc
);
  localparam int PL = AW - 4;

  logic [AW-1:0] io_base;
  logic [AW-1:0] ram_base;
  logic [AW-1:0] io_dist;
  logic          reloc_wr;

  always_comb begin
    io_base  = {reloc[3:0], {PL{1'b0}}};
    ram_base = {reloc[7:4], {PL{1'b0}}};
    io_dist  = addr - io_base;
    reloc_wr = wr_en && sel[0] && (offset == AW'(RELOC_OFS));
  end

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(sel));
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    unmapped == (sel == 5'b0));
  assert_zero_offset_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    unmapped |-> offset == '0);
  assert_io_offset_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    sel[0] |-> offset == io_dist);
  assert_ram_offset_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    sel[3] |-> offset == addr - ram_base);
  assert_io_wins_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    ({1'b0, io_dist} < (AW+1)'(IO_SIZE)) |-> sel[0]);
  assert_reloc_load_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    reloc_wr |=> reloc == $past(wr_data));
  assert_reloc_hold_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !reloc_wr |=> $stable(reloc));
endmodule

bind mem_region_decoder mrd_checker #(
  .AW(ADDR_W), .IO_SIZE(IO_SIZE), .RELOC_OFS(RELOC_OFS)
) chk_i (
  .clk(clk), .rst_ok(rst_sync_n), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .sel(sel), .offset(offset), .unmapped(unmapped),
  .reloc(reloc_q)
);

// File: tb/mem_region_decoder_tb_top.sv
`timescale 1ns/1ps
module mem_region_decoder_tb_top;
  localparam logic [4:0] S_IO = 5'b00001, S_EEP = 5'b00010, S_NVR = 5'b00100,
                         S_RAM = 5'b01000, S_XRAM = 5'b10000, S_NONE = 5'b00000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [4:0] sel;
  logic [15:0] offset;
  logic unmapped;

  logic [15:0] a1 = 16'h0000;
  logic [4:0] s1;
  logic [15:0] o1;
  logic u1;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] a;
    logic [4:0]  s;
    logic [15:0] o;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  mem_region_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .sel(sel), .offset(offset), .unmapped(unmapped)
  );

  mem_region_decoder #(.CPU_VARIANT(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .addr(a1), .wr_en(1'b0), .wr_data(8'h00),
    .sel(s1), .offset(o1), .unmapped(u1)
  );

  task automatic check(input string tag, input logic [15:0] a,
                       input logic [4:0] gs, input logic [15:0] go, input logic gu,
                       input logic [4:0] es, input logic [15:0] eo);
    n_run++;
    if (gs !== es || go !== eo || gu !== (es == 5'b0)) begin
      n_fail++;
      $display("FAIL %s addr=%h actual sel=%b off=%h unm=%b expected sel=%b off=%h unm=%b",
               tag, a, gs, go, gu, es, eo, (es == 5'b0));
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] d,
                       input logic [4:0] s, input logic [15:0] o, input string tag);
    @(negedge clk);
    addr = a; wr_en = w; wr_data = d;
    exp_q.push_back('{a, s, o, tag});
  endtask

  // Monitor: compare each pushed item a little after its negedge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        check(it.tag, it.a, sel, offset, unmapped, it.s, it.o);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset placement
    drive(16'h1000, 0, 0, S_IO,   16'h0000, "R1 io at 0x1000");
    drive(16'h0000, 0, 0, S_RAM,  16'h0000, "R1 ram at 0x0000");
    drive(16'h103F, 0, 0, S_IO,   16'h003F, "R7 io last byte");
    drive(16'h1040, 0, 0, S_NONE, 16'h0000, "R7 io one past end");
    drive(16'h00FF, 0, 0, S_RAM,  16'h00FF, "R3 ram last byte");
    drive(16'h0100, 0, 0, S_NONE, 16'h0000, "R10 past ram");
    drive(16'hB123, 0, 0, S_EEP,  16'h0123, "R3 eeprom offset");
    drive(16'h9FFF, 0, 0, S_NVR,  16'h1FFF, "R3 nvram end");
    drive(16'h2000, 0, 0, S_XRAM, 16'h0000, "R3 xram start");
    drive(16'h7FFF, 0, 0, S_XRAM, 16'h5FFF, "R3 xram end");
    drive(16'hA000, 0, 0, S_NONE, 16'h0000, "R10 hole");
    drive(16'hFFFF, 0, 0, S_NONE, 16'h0000, "R10 top");
    // R9 near-miss writes
    drive(16'h103B, 1, 8'h55, S_IO,  16'h003B, "R9 wrong offset write");
    drive(16'h003C, 1, 8'h00, S_RAM, 16'h003C, "R9 write outside io");
    drive(16'h1000, 0, 0, S_IO,  16'h0000, "R9 io unmoved");
    drive(16'h0000, 0, 0, S_RAM, 16'h0000, "R9 ram unmoved");
    // R8 relocate both to page 0
    drive(16'h103C, 1, 8'h00, S_IO, 16'h003C, "R8 write cycle old map");
    drive(16'h1000, 0, 0, S_NONE, 16'h0000, "R4 old io page gone");
    drive(16'h0010, 0, 0, S_IO,   16'h0010, "R6 io over ram");
    drive(16'h003F, 0, 0, S_IO,   16'h003F, "R6 io end over ram");
    drive(16'h0040, 0, 0, S_RAM,  16'h0040, "R6 ram past io");
    // io to 0xB000, ram to 0x8000
    drive(16'h003C, 1, 8'h8B, S_IO, 16'h003C, "R8 write at new io");
    drive(16'hB000, 0, 0, S_IO,   16'h0000, "R6 io over eeprom");
    drive(16'hB03F, 0, 0, S_IO,   16'h003F, "R6 io end over eeprom");
    drive(16'hB040, 0, 0, S_EEP,  16'h0040, "R6 eeprom past io");
    drive(16'h8000, 0, 0, S_NVR,  16'h0000, "R6 nvram over ram");
    drive(16'h0000, 0, 0, S_NONE, 16'h0000, "R5 ram left page 0");
    // io to 0x1000, ram to 0x2000
    drive(16'hB03C, 1, 8'h21, S_IO, 16'h003C, "R8 write third");
    drive(16'h2000, 0, 0, S_RAM,  16'h0000, "R6 ram over xram");
    drive(16'h20FF, 0, 0, S_RAM,  16'h00FF, "R5 ram end");
    drive(16'h2100, 0, 0, S_XRAM, 16'h0100, "R6 xram past ram");
    // back-to-back: write then reuse same address
    drive(16'h103C, 1, 8'h0F, S_IO, 16'h003C, "R8 write to F page");
    drive(16'h103C, 0, 0, S_NONE, 16'h0000, "R8 next cycle new map");
    drive(16'hF03C, 0, 0, S_IO,   16'h003C, "R4 io at 0xF000");
    drive(16'h0000, 0, 0, S_RAM,  16'h0000, "R5 ram at page 0");
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    // R7 large variant
    a1 = 16'h13FF; #1; check("R7 large io end", a1, s1, o1, u1, S_IO, 16'h03FF);
    @(negedge clk); a1 = 16'h1040; #1; check("R7 large io mid", a1, s1, o1, u1, S_IO, 16'h0040);
    @(negedge clk); a1 = 16'h1400; #1; check("R7 large io past", a1, s1, o1, u1, S_NONE, 16'h0000);
    @(negedge clk); a1 = 16'h0000; #1; check("R1 large ram", a1, s1, o1, u1, S_RAM, 16'h0000);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule